// File: doc/BRIEF.md
# Armed Pulsed Relay Command Controller

This block drives a bank of discrete outputs, one per latching relay channel. Each output delivers a single timed high pulse when commanded. Commands arrive as byte writes on a small register-write port. Firing any channel takes two steps. First, an exact enable key is written to the arm register. Then the channel's own code is written to the fire register. Any other byte is rejected, including the bitwise inverse of a channel code. Only one channel can be pulsing at any moment.

The pulse width is measured in system clock cycles. The cycle count is derived from the clock-frequency and pulse-duration parameters. The counter width is sized from that product, so the count never overflows. A single status byte reports the following:
- whether the block is armed;
- whether a pulse is in flight;
- the index of the last channel fired;
- two sticky flags, one for rejected commands and one for commands that arrived while busy.

Reading the status clears the two flags.

Top module: `relay_pulse_ctrl`

## Requirements
- R1: After reset every bit of `pulse_out` is low and the status byte reads 0x00.
- R2: Writing 0x5A to register select 0 arms the block (status bit 7 = 1). Every other byte written there leaves the block disarmed and sets the bad-command flag (status bit 4).
- R3: Channel i is selected by the code 0xC0 + i. Writing that code to register select 1 while armed raises only `pulse_out[i]`, starting at the clock edge that captures the write.
- R4: No more than one bit of `pulse_out` is high at any time. A raised bit holds steady until its pulse ends.
- R5: A pulse stays high for exactly CLK_HZ*PULSE_MS/1000 clock cycles and then returns low.
- R6: A fire write while disarmed raises no output and sets the bad-command flag.
- R7: Any fire write consumes the armed state. A byte that is not a channel code fires nothing and sets the bad-command flag. This covers codes at or above 0xC0+NUM_CH and the bitwise inverse of every valid code.
- R8: The armed state lapses on its own after ARM_TIMEOUT clock cycles without a fire write. A later fire write then has no effect.
- R9: While a pulse is active, arm and fire writes are ignored: the armed state and the outputs are left unchanged. Each such write sets the busy-reject flag (status bit 5).
- R10: The status byte is {armed, active, busy_reject, bad_command, last_channel[3:0]}. A read (`rd_en` high for one cycle) clears bits 5 and 4 at that edge. `rd_data` always shows the current status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one cycle per command |
| wr_sel | input | 2 | Register select: 0 arm, 1 fire, others ignored |
| wr_data | input | 8 | Command byte |
| rd_en | input | 1 | Status read strobe; clears the sticky flags |
| rd_data | output | 8 | Status byte |
| pulse_out | output | NUM_CH | Registered pulse outputs, one per channel |

## Verification
The bench builds the block with NUM_CH=16, CLK_HZ=1000 and PULSE_MS=50, which gives a 50-cycle pulse. It also sets ARM_TIMEOUT=20. These values put the full pulse width and the arm timeout within a few dozen cycles. Every channel can therefore be fired and timed end to end. Three byte spaces are swept in full:
- all 256 arm values;
- all 256 fire values while disarmed;
- every non-code fire value while armed.

These sweeps cover every complementary pattern against the exact-match rules.

// File: rtl/relay_pkg.sv
package relay_pkg;
  localparam logic [7:0] ARM_KEY   = 8'h5A;
  localparam logic [7:0] CODE_BASE = 8'hC0;

  typedef enum logic [1:0] {
    SEL_ARM   = 2'd0,
    SEL_FIRE  = 2'd1,
    SEL_SPARE = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       armed;
    logic       active;
    logic       busy_rej;
    logic       bad_cmd;
    logic [3:0] last_ch;
  } status_t;
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode #(
  parameter int NUM_CH = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [7:0]      code,
  output logic            hit,
  output logic [CH_W-1:0] idx
);
  import relay_pkg::*;

  logic [NUM_CH-1:0] match;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_match
    assign match[g] = (code == (CODE_BASE + 8'(g)));
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (match[i]) idx = idx | CH_W'(i);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/arm_guard.sv
module arm_guard #(
  parameter int ARM_TIMEOUT = 20,
  localparam int AW = $clog2(ARM_TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_set,
  input  logic arm_clr,
  output logic armed
);
  logic          armed_q, armed_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (arm_set) begin
      armed_d = 1'b1;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else if (arm_clr) begin
      armed_d = 1'b0;
    end else if (armed_q) begin
      if (cnt_q == AW'(ARM_TIMEOUT - 1)) begin
        armed_d = 1'b0;
      end else begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign armed = armed_q;

  AST_ARM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (cnt_q < AW'(ARM_TIMEOUT))); // R8
  AST_ARM_LAPSE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !arm_set && !arm_clr && cnt_q == AW'(ARM_TIMEOUT - 1)) |=> !armed_q); // R8
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int          NUM_CH       = 16,
  parameter int unsigned CLK_HZ       = 50_000_000,
  parameter int unsigned PULSE_MS     = 50,
  localparam int         CH_W         = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam longint unsigned PULSE_CYC = (64'(CLK_HZ) * 64'(PULSE_MS)) / 64'd1000,
  localparam int         PW           = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CH_W-1:0]   start_idx,
  output logic [NUM_CH-1:0] pulse_out,
  output logic              active
);
  logic [NUM_CH-1:0] out_q, out_d;
  logic [PW-1:0]     cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    out_d  = out_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (start) begin
      out_d  = NUM_CH'(1) << start_idx;
      cnt_d  = PW'(PULSE_CYC - 1);
      cnt_en = 1'b1;
    end else if (|out_q) begin
      if (cnt_q == '0) begin
        out_d = '0;
      end else begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pulse_out = out_q;
  assign active    = |out_q;

  AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulse_out)); // R4
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active) && active) |-> $stable(pulse_out)); // R4
  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt_q != '0) |=> active); // R5
  AST_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(cnt_q) == '0)); // R5
endmodule

// File: rtl/relay_pulse_ctrl.sv
module relay_pulse_ctrl #(
  parameter int          NUM_CH      = 16,
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned PULSE_MS    = 50,
  parameter int          ARM_TIMEOUT = 1024,
  localparam int         CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic [NUM_CH-1:0] pulse_out
);
  import relay_pkg::*;

  logic            srst_n;
  logic            armed, active, hit;
  logic [CH_W-1:0] idx;
  logic            wr_arm, wr_fire;
  logic            arm_set, arm_clr, fire_ok, bad_now, busy_now;
  logic            busy_q, busy_d, bad_q, bad_d;
  logic [CH_W-1:0] last_q;
  status_t         status;

  rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  cmd_decode #(.NUM_CH(NUM_CH)) u_dec (.code(wr_data), .hit(hit), .idx(idx));

  assign wr_arm  = wr_en && (reg_sel_e'(wr_sel) == SEL_ARM);
  assign wr_fire = wr_en && (reg_sel_e'(wr_sel) == SEL_FIRE);

  assign busy_now = (wr_arm || wr_fire) && active;
  assign arm_set  = wr_arm && !active && (wr_data == ARM_KEY);
  assign arm_clr  = (wr_arm && !active && (wr_data != ARM_KEY)) ||
                    (wr_fire && !active);
  assign fire_ok  = wr_fire && !active && armed && hit;
  assign bad_now  = (wr_arm && !active && (wr_data != ARM_KEY)) ||
                    (wr_fire && !active && !(armed && hit));

  arm_guard #(.ARM_TIMEOUT(ARM_TIMEOUT)) u_arm (
    .clk(clk), .rst_n(srst_n), .arm_set(arm_set), .arm_clr(arm_clr), .armed(armed)
  );

  pulse_timer #(.NUM_CH(NUM_CH), .CLK_HZ(CLK_HZ), .PULSE_MS(PULSE_MS)) u_tmr (
    .clk(clk), .rst_n(srst_n), .start(fire_ok), .start_idx(idx),
    .pulse_out(pulse_out), .active(active)
  );

  always_comb begin
    busy_d = busy_q;
    bad_d  = bad_q;
    if (rd_en) begin
      busy_d = 1'b0;
      bad_d  = 1'b0;
    end
    if (busy_now) busy_d = 1'b1;
    if (bad_now)  bad_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      busy_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      bad_q  <= bad_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      last_q <= '0;
    else if (fire_ok) last_q <= idx;
  end

  always_comb begin
    status.armed    = armed;
    status.active   = active;
    status.busy_rej = busy_q;
    status.bad_cmd  = bad_q;
    status.last_ch  = 4'(last_q);
  end

  assign rd_data = status;

  AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(active) |-> $past(armed)); // R6
  AST_BUSY_KEEPS_DISARMED: assert property (@(posedge clk) disable iff (!srst_n)
    (active && wr_arm && !armed) |=> !armed); // R9
  AST_BUSY_FLAG: assert property (@(posedge clk) disable iff (!srst_n)
    (active && (wr_arm || wr_fire)) |=> busy_q); // R9
  AST_FIRE_CONSUMES: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_fire && !active) |=> !armed); // R7
endmodule

// File: tb/tb_relay_pulse_ctrl.sv
module tb_relay_pulse_ctrl;
  localparam int NCH   = 16;
  localparam int PCYC  = 50;
  localparam int TOUT  = 20;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           wr_en;
  logic [1:0]     wr_sel;
  logic [7:0]     wr_data;
  logic           rd_en;
  logic [7:0]     rd_data;
  logic [NCH-1:0] pulse_out;

  int n_chk = 0;
  int n_bad = 0;

  relay_pulse_ctrl #(.NUM_CH(NCH), .CLK_HZ(1000), .PULSE_MS(50), .ARM_TIMEOUT(TOUT)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pulse_out(pulse_out)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1;
    v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic time_pulse(input int ch, input string req);
    int w = 0;
    logic [NCH-1:0] exp = NCH'(1) << ch;
    while (pulse_out != '0 && w < 4 * PCYC) begin
      if (pulse_out != exp) chk(1'b0, "R4", int'(pulse_out), int'(exp));
      w++;
      @(negedge clk);
    end
    chk(w == PCYC, req, w, PCYC);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] s;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_en = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk(pulse_out == '0, "R1", int'(pulse_out), 0);
    rd(s);
    chk(s == 8'h00, "R1", s, 0);

    // R3 / R5 / R10: every channel fires with its own code
    for (int ch = 0; ch < NCH; ch++) begin
      wr(2'd0, 8'h5A);
      rd(s);
      chk(s[7] == 1'b1, "R2", s, 8'h80);
      wr(2'd1, 8'hC0 + 8'(ch));
      chk(pulse_out == (NCH'(1) << ch), "R3", int'(pulse_out), 1 << ch);
      time_pulse(ch, "R5");
      rd(s);
      chk(s == 8'(ch), "R10", s, ch);
    end

    // R2: every non-key arm byte leaves the block disarmed
    for (int v = 0; v < 256; v++) begin
      if (v != 8'h5A) begin
        wr(2'd0, 8'(v));
        rd(s);
        chk(s[7] == 1'b0 && s[4] == 1'b1, "R2", s, 8'h10 | (s & 8'h0F));
      end
    end

    // R6: fire writes while disarmed, all bytes
    for (int v = 0; v < 256; v++) begin
      wr(2'd1, 8'(v));
      chk(pulse_out == '0, "R6", int'(pulse_out), 0);
      rd(s);
      chk(s[4] == 1'b1 && s[6] == 1'b0, "R6", s, 8'h10 | (s & 8'h0F));
    end

    // R7: armed, every non-code byte (inverses included) fires nothing
    for (int v = 0; v < 256; v++) begin
      if (v < 8'hC0 || v >= 8'hC0 + NCH) begin
        wr(2'd0, 8'h5A);
        wr(2'd1, 8'(v));
        chk(pulse_out == '0, "R7", int'(pulse_out), 0);
        rd(s);
        chk(s[7] == 1'b0 && s[4] == 1'b1, "R7", s, 8'h10 | (s & 8'h0F));
      end
    end

    // R7: one fire write consumes the arm
    wr(2'd0, 8'h5A);
    wr(2'd1, 8'hFF);
    wr(2'd1, 8'hC2);
    chk(pulse_out == '0, "R7", int'(pulse_out), 0);
    rd(s);

    // R8: arm lapses after the timeout
    wr(2'd0, 8'h5A);
    idle(TOUT + 2);
    rd(s);
    chk(s[7] == 1'b0, "R8", s, s & 8'h7F);
    wr(2'd1, 8'hC1);
    chk(pulse_out == '0, "R8", int'(pulse_out), 0);
    rd(s);

    // R8: fire inside the window still works
    wr(2'd0, 8'h5A);
    idle(TOUT - 4);
    wr(2'd1, 8'hC5);
    chk(pulse_out == (NCH'(1) << 5), "R8", int'(pulse_out), 1 << 5);

    // R9: writes during a pulse are ignored
    wr(2'd0, 8'h5A);
    rd(s);
    chk(s[7] == 1'b0 && s[6] == 1'b1 && s[5] == 1'b1, "R9", s, 8'h65);
    rd(s);
    chk(s[5] == 1'b0, "R10", s, s & 8'hDF);
    wr(2'd1, 8'hC3);
    chk(pulse_out == (NCH'(1) << 5), "R9", int'(pulse_out), 1 << 5);
    idle(PCYC);
    chk(pulse_out == '0, "R5", int'(pulse_out), 0);
    rd(s);
    chk(s == 8'h25, "R10", s, 8'h25);
    rd(s);
    chk(s == 8'h05, "R10", s, 8'h05);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule